// File: doc/BRIEF.md
# Interrupt Message Event Queue

This block turns inbound message-signalled interrupt writes into records in a circular queue held in system memory. Each accepted message becomes one 16-byte record. The record goes out on a memory write-request port at the address formed by a programmable 64-bit queue base plus the current write offset. Software drains the queue by reading records and then moving the read offset forward. A level interrupt line stays high while unread records remain.

The queue size is one of four powers of two, from 32 KB to 256 KB, selected by a two-bit code. Fill state is held only as two byte offsets, which always stay 16-byte aligned and inside the ring. When the ring is full, and full detection is on, one of two policies applies. The block can hold the message off by keeping its ready signal low. Or it can take the message, throw it away and record the loss in a sticky flag.

Top module: `msi_event_queue`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq` is 0, `mem_valid` is 0 and `msi_ready` is 0.
- R2: The register bus decodes these addresses: 0 is control, 3 is base high (address bits 63:32), 4 is base low (bits 31:0), 5 is read offset and 6 is write offset. The write offset is read-only, and an unmapped address reads zero.
- R3: An accepted, non-dropped message produces one request. Its `mem_addr` equals {base high, base low} plus the write offset. Its `mem_data[31:0]` holds the low 16 bits of `msi_data`, zero-extended, and `mem_data[127:32]` is zero.
- R4: The write offset advances by 16 only on a completed memory handshake. It wraps to zero at the ring size of 2^(15+code) bytes, where the code sits in control bits 9:8.
- R5: A value written to the read offset is stored with bits 3:0 cleared and with every bit at or above the ring-size exponent cleared.
- R6: `irq` is high exactly when control bit 0 (enable) and bit 3 (interrupt enable) are both set and the two offsets differ.
- R7: With control bit 1 (full detection) and bit 4 (stop when full) set, the ring counts as full when the write offset plus 16, wrapped, equals the read offset. While it is full, `msi_ready` stays low. Acceptance resumes once the read offset moves.
- R8: With bit 1 set, bit 4 clear and the ring full, a message is accepted but issues no request and leaves the write offset unchanged. It also sets the sticky control bit 16. A control write with bit 16 set clears that bit.
- R9: With bit 1 clear, messages are written regardless of the read offset.
- R10: With bit 0 clear, `msi_ready` is low and no request is issued.
- R11: A control write that changes bits 9:8 sets both offsets to zero.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| msi_valid | input | 1 | Inbound message present |
| msi_data | input | 32 | Inbound message data word |
| msi_ready | output | 1 | Inbound message accepted this cycle |
| mem_valid | output | 1 | Record write request |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents, bytes 0 to 3 in bits 31:0 |
| mem_ready | input | 1 | Memory takes the request |
| irq | output | 1 | Level interrupt: unread records pending |

## Verification
Some properties are checked on every cycle by the assertions. Both offsets stay 16-byte aligned, and a pending request holds steady under backpressure. An accepted message that is not dropped always yields a request on the next cycle. The write offset moves only after a handshake or a size change, and the loss flag rises only when a message was offered in drop mode. Other behaviours can only be shown by the bench scenarios. These are the exact record address and payload, wrap-around at the ring size, holding and then resuming in stop mode, discard in drop mode, and the interaction between the interrupt level and the register writes.

// File: rtl/meq_pkg.sv
package meq_pkg;

    localparam int BASE_EXP  = 15;             // smallest ring is 2^BASE_EXP bytes
    localparam int SIZE_W    = 2;              // ring size code width
    localparam int OFS_W     = BASE_EXP + (1 << SIZE_W) - 1;
    localparam int REC_SHIFT = 4;
    localparam int REC_BYTES = 1 << REC_SHIFT;
    localparam int REG_W     = 32;
    localparam int ADR_W     = 64;
    localparam int NUM_W     = 16;
    localparam int REC_W     = REC_BYTES * 8;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_BASE_HI = 3'd3;
    localparam logic [2:0] RA_BASE_LO = 3'd4;
    localparam logic [2:0] RA_RD_OFS  = 3'd5;
    localparam logic [2:0] RA_WR_OFS  = 3'd6;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              stop_full;
        logic              irq_en;
        logic              full_det;
        logic              enable;
    } ctrl_t;

    typedef struct packed {
        logic [ADR_W-1:0] addr;
        logic [NUM_W-1:0] num;
    } rec_t;

    function automatic logic [OFS_W-1:0] ofs_mask(input logic [SIZE_W-1:0] size);
        logic [OFS_W-1:0] m;
        m = '0;
        for (int i = REC_SHIFT; i < OFS_W; i++)
            if (i < BASE_EXP + int'(size)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [OFS_W-1:0] ofs_next(input logic [OFS_W-1:0] ofs,
                                                  input logic [SIZE_W-1:0] size);
        return (ofs + OFS_W'(REC_BYTES)) & ofs_mask(size);
    endfunction

endpackage

// File: rtl/meq_regs.sv
module meq_regs
    import meq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic              drop_evt,
    output ctrl_t             ctrl,
    output logic [ADR_W-1:0]  base,
    output logic [OFS_W-1:0]  rd_ofs,
    output logic              ofs_clear,
    output logic              overflow
);

    logic [REG_W-1:0] base_hi, base_lo;
    logic             wr_ctrl, wr_rd;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:17], reg_wdata[15:10], reg_wdata[7:5], reg_wdata[2]};

    assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
    assign wr_rd     = reg_we && (reg_addr == RA_RD_OFS);
    assign ofs_clear = wr_ctrl && (reg_wdata[9:8] != ctrl.size);
    assign base      = {base_hi, base_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            base_hi  <= '0;
            base_lo  <= '0;
            rd_ofs   <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.enable    <= reg_wdata[0];
                ctrl.full_det  <= reg_wdata[1];
                ctrl.irq_en    <= reg_wdata[3];
                ctrl.stop_full <= reg_wdata[4];
                ctrl.size      <= reg_wdata[9:8];
            end
            if (reg_we && reg_addr == RA_BASE_HI) base_hi <= reg_wdata;
            if (reg_we && reg_addr == RA_BASE_LO) base_lo <= reg_wdata;
            if (ofs_clear)
                rd_ofs <= '0;
            else if (wr_rd)
                rd_ofs <= reg_wdata[OFS_W-1:0] & ofs_mask(ctrl.size);
            if (drop_evt)
                overflow <= 1'b1;
            else if (wr_ctrl && reg_wdata[16])
                overflow <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rdata = {15'd0, overflow, 6'd0, ctrl.size, 3'd0,
                                     ctrl.stop_full, ctrl.irq_en, 1'b0,
                                     ctrl.full_det, ctrl.enable};
            RA_BASE_HI: reg_rdata = base_hi;
            RA_BASE_LO: reg_rdata = base_lo;
            RA_RD_OFS:  reg_rdata = REG_W'(rd_ofs);
            RA_WR_OFS:  reg_rdata = REG_W'(wr_ofs);
            default:    reg_rdata = '0;
        endcase
    end

    // R5: stored read offset is always record aligned
    a_r5_rd_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_ofs[REC_SHIFT-1:0] == '0);

endmodule

// File: rtl/meq_writer.sv
module meq_writer
    import meq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADR_W-1:0]  base,
    input  logic [OFS_W-1:0]  rd_ofs,
    input  logic              ofs_clear,
    input  logic              msi_valid,
    input  logic [NUM_W-1:0]  msi_num,
    output logic              msi_ready,
    output logic              mem_valid,
    output logic [ADR_W-1:0]  mem_addr,
    output logic [REC_W-1:0]  mem_data,
    input  logic              mem_ready,
    output logic [OFS_W-1:0]  wr_ofs,
    output logic              drop_evt
);

    logic             busy;
    rec_t             rec;
    logic [OFS_W-1:0] nxt;
    logic             full, take, done;

    assign nxt       = ofs_next(wr_ofs, ctrl.size);
    assign full      = ctrl.full_det && (nxt == rd_ofs);
    assign msi_ready = ctrl.enable && !busy && !(full && ctrl.stop_full);
    assign take      = msi_valid && msi_ready;
    assign drop_evt  = take && full;
    assign done      = busy && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            rec    <= '0;
            wr_ofs <= '0;
        end else begin
            if (take && !full) begin
                busy     <= 1'b1;
                rec.addr <= base + ADR_W'(wr_ofs);
                rec.num  <= msi_num;
            end else if (done) begin
                busy <= 1'b0;
            end
            if (ofs_clear)
                wr_ofs <= '0;
            else if (done)
                wr_ofs <= nxt;
        end
    end

    assign mem_valid = busy;
    assign mem_addr  = rec.addr;
    assign mem_data  = {{(REC_W-NUM_W){1'b0}}, rec.num};

    // R12: request held steady under backpressure
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R3: a kept message always yields a request next cycle
    a_r3_take_req: assert property (@(posedge clk) disable iff (rst)
        msi_valid && msi_ready && !drop_evt |=> mem_valid);

    // R4: write offset aligned and moves only on handshake or size change
    a_r4_wr_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_ofs[REC_SHIFT-1:0] == '0);

    a_r4_wr_moves: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_ofs) |-> $past(ofs_clear) || $past(mem_valid && mem_ready));

endmodule

// File: rtl/msi_event_queue.sv
module msi_event_queue
    import meq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          msi_valid,
    input  logic [31:0]   msi_data,
    output logic          msi_ready,
    output logic          mem_valid,
    output logic [63:0]   mem_addr,
    output logic [127:0]  mem_data,
    input  logic          mem_ready,
    output logic          irq
);

    ctrl_t            ctrl;
    logic [ADR_W-1:0] base;
    logic [OFS_W-1:0] rd_ofs, wr_ofs;
    logic             ofs_clear, drop_evt, overflow;
    logic             unused_msi;

    assign unused_msi = ^msi_data[31:NUM_W];

    meq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_ofs    (wr_ofs),
        .drop_evt  (drop_evt),
        .ctrl      (ctrl),
        .base      (base),
        .rd_ofs    (rd_ofs),
        .ofs_clear (ofs_clear),
        .overflow  (overflow)
    );

    meq_writer u_writer (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .base      (base),
        .rd_ofs    (rd_ofs),
        .ofs_clear (ofs_clear),
        .msi_valid (msi_valid),
        .msi_num   (msi_data[NUM_W-1:0]),
        .msi_ready (msi_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ready (mem_ready),
        .wr_ofs    (wr_ofs),
        .drop_evt  (drop_evt)
    );

    assign irq = ctrl.enable && ctrl.irq_en && (rd_ofs != wr_ofs);

    // R8: loss flag rises only after a message offered in drop mode
    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(msi_valid && !ctrl.stop_full));

    // R10: a disabled block never takes a message
    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |-> !(msi_valid && msi_ready) || !$past(!ctrl.enable) || !msi_ready);

endmodule

// File: tb/msi_event_queue_bench.sv
module msi_event_queue_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_we;
    logic [2:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         msi_valid;
    logic [31:0]  msi_data;
    logic         msi_ready;
    logic         mem_valid;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_ready;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int rec_cnt = 0;
    logic [63:0]  last_addr;
    logic [127:0] last_data;

    always #5 clk = ~clk;

    msi_event_queue u_msi_event_queue (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_data(msi_data), .msi_ready(msi_ready), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            rec_cnt   <= rec_cnt + 1;
            last_addr <= mem_addr;
            last_data <= mem_data;
        end
    end

    localparam int NV = 7;
    localparam logic [2:0]  VA [NV] = '{3'd3, 3'd4, 3'd0, 3'd5, 3'd6, 3'd1, 3'd7};
    localparam logic [31:0] VW [NV] = '{32'h1234_5678, 32'h9ABC_0000, 32'h0000_001B,
                                        32'h0001_2345, 32'h0000_0100, 32'hFFFF_FFFF,
                                        32'h5555_5555};
    localparam logic [31:0] VE [NV] = '{32'h1234_5678, 32'h9ABC_0000, 32'h0000_001B,
                                        32'h0000_2340, 32'h0000_0000, 32'h0000_0000,
                                        32'h0000_0000};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_msi(input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = d;
        forever begin
            #1;
            if (msi_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        msi_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_500_000ns;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int c0;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        msi_valid = 1'b0; msi_data = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_read(3'd0, rd); chk("R1 ctrl", rd, 0);
        reg_read(3'd6, rd); chk("R1 wr ofs", rd, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 msi_ready", msi_ready, 0);

        // R2 / R5: register vector table
        for (int i = 0; i < NV; i++) begin
            reg_write(VA[i], VW[i]);
            reg_read(VA[i], rd);
            chk("R2 R5 register table", rd, VE[i]);
        end

        // R11: size change clears offsets (size 0 -> 1)
        reg_write(3'd0, 32'h0000_0109);
        reg_read(3'd5, rd); chk("R11 rd cleared", rd, 0);
        reg_read(3'd6, rd); chk("R11 wr cleared", rd, 0);
        chk("R6 irq when empty", irq, 0);

        // R3: record address and payload
        send_msi(32'hABCD_0042);
        chk("R3 addr", last_addr, 64'h1234_5678_9ABC_0000);
        chk("R3 data", last_data, 128'h42);
        reg_read(3'd6, rd); chk("R4 wr +16", rd, 32'h10);
        chk("R6 irq pending", irq, 1);
        reg_write(3'd5, 32'h10);
        #1 chk("R6 irq cleared", irq, 0);
        send_msi(32'h0000_0007);
        chk("R3 addr 2", last_addr, 64'h1234_5678_9ABC_0010);
        chk("R3 data 2", last_data, 128'h7);
        reg_write(3'd0, 32'h0000_0101);
        #1 chk("R6 irq_en off", irq, 0);

        // R12: backpressure
        mem_ready = 1'b0;
        c0 = rec_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h0000_0099;
        @(negedge clk); msi_valid = 1'b0;
        chk("R12 valid up", mem_valid, 1);
        chk("R12 addr", mem_addr, 64'h1234_5678_9ABC_0020);
        repeat (3) @(negedge clk);
        chk("R12 valid held", mem_valid, 1);
        chk("R12 addr held", mem_addr, 64'h1234_5678_9ABC_0020);
        chk("R12 data held", mem_data, 128'h99);
        chk("R12 no new msi", msi_ready, 0);
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R12 done", rec_cnt, c0 + 1);
        reg_read(3'd6, rd); chk("R4 wr after stall", rd, 32'h30);

        // R7: stop when full
        reg_write(3'd0, 32'h0000_0113);
        reg_write(3'd5, 32'h50);
        send_msi(32'h1);
        reg_read(3'd6, rd); chk("R7 wr before full", rd, 32'h40);
        c0 = rec_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h2;
        repeat (3) @(negedge clk);
        #1 chk("R7 ready low when full", msi_ready, 0);
        chk("R7 no record when full", rec_cnt, c0);
        reg_write(3'd5, 32'h60);
        repeat (4) @(negedge clk);
        msi_valid = 1'b0;
        @(negedge clk);
        chk("R7 resumed one record", rec_cnt, c0 + 1);
        reg_read(3'd6, rd); chk("R7 wr after resume", rd, 32'h50);

        // R8: drop when full
        reg_write(3'd0, 32'h0000_0103);
        c0 = rec_cnt;
        send_msi(32'h3);
        chk("R8 no record", rec_cnt, c0);
        reg_read(3'd6, rd); chk("R8 wr unchanged", rd, 32'h50);
        reg_read(3'd0, rd); chk("R8 overflow set", rd, 32'h0001_0103);
        reg_write(3'd0, 32'h0001_0103);
        reg_read(3'd0, rd); chk("R8 overflow cleared", rd, 32'h0000_0103);

        // R9: no full detection
        reg_write(3'd0, 32'h0000_0101);
        send_msi(32'h4);
        send_msi(32'h5);
        reg_read(3'd6, rd); chk("R9 wr past rd", rd, 32'h70);

        // R10: disabled
        reg_write(3'd0, 32'h0000_0100);
        c0 = rec_cnt;
        @(negedge clk); msi_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R10 ready low", msi_ready, 0);
        msi_valid = 1'b0;
        chk("R10 no record", rec_cnt, c0);

        // R4 / R11: wrap at 32 KB ring
        reg_write(3'd0, 32'h0000_0001);
        reg_read(3'd6, rd); chk("R11 wr reset on size", rd, 0);
        for (int k = 0; k < 2048; k++) send_msi(k);
        chk("R4 last addr", last_addr, 64'h1234_5678_9ABC_7FF0);
        reg_read(3'd6, rd); chk("R4 wrap to zero", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule